// File: doc/BRIEF.md
# Serial Flash Single-I/O Read Responder

This block is the memory side of a serial flash device, serving only the basic single-line read command. While chip select is low, it takes the instruction byte and then the address from the serial input, one bit per serial clock rising edge. It then returns array bytes on the serial output, most significant bit first, changing the output on serial clock falling edges. It inserts no wait bits between the address and the data. The read address steps up by one after every byte and wraps to zero at the top of the array. A single command can therefore stream the whole array for as long as the host keeps clocking. Raising chip select ends the command at any bit.

Two opcodes are accepted. Opcode 0x03 takes a 3-byte address when the extended-address configuration input is 0, and a 4-byte address when it is 1. Opcode 0x13 always takes a 4-byte address.

The serial pins are sampled with the block's own system clock through a short synchronizer. The serial clock is assumed to be much slower than the system clock. The array sits outside the block behind a synchronous read port with one cycle of latency.

Top module: `sfr_read`

## Requirements
- R1: After reset, and while chip select has been high for three or more system clocks, `so_oe` is 0 and no memory read is issued.
- R2: Opcode 0x03 with `cfg_ext_addr`=0 is followed by 24 address bits, most significant first. The data bytes returned on `so` are the array bytes starting at that address, each byte most significant bit first.
- R3: Opcode 0x03 with `cfg_ext_addr`=1 is followed by 32 address bits, most significant first.
- R4: Opcode 0x13 is followed by 32 address bits for either value of `cfg_ext_addr`.
- R5: `so_oe` is 0 during the instruction and address bits. It becomes 1 on the serial clock falling edge that follows the last address bit, and that same edge presents the first data bit, with no dummy bits. `so` changes only after serial clock falling edges.
- R6: After each byte, the read address increments by one, so consecutive bytes come from consecutive addresses. Each memory read is a single-cycle `mem_rd_en` pulse, and `mem_rdata` is taken one system clock later.
- R7: The address is taken modulo 2^AW, ignoring the upper address bits. After byte 2^AW-1 the stream continues with byte 0.
- R8: Raising chip select at any bit of the data phase ends the read and drops `so_oe`. The next command starts again from its first instruction bit.
- R9: For an opcode other than 0x03 or 0x13, `so_oe` stays 0 for every following bit until chip select goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ext_addr | input | 1 | Selects the 4-byte address for opcode 0x03; must be stable during a command |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock; each half period spans at least 4 system clocks |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host, valid while so_oe is 1 |
| so_oe | output | 1 | Output-driver enable for so; 0 means high impedance |
| mem_rd_en | output | 1 | Single-cycle array read strobe |
| mem_addr | output | AW | Array byte address |
| mem_rdata | input | 8 | Array data, valid one clock after mem_rd_en |

## Verification
The array model returns a byte computed from the address, so a read shifted by even one bit or one byte produces a wrong value. The 3-byte and 4-byte forms of opcode 0x03 are tried, along with opcode 0x13 under both settings of the configuration input. These runs show whether the address length follows the opcode and the configuration bit. Start addresses just below the top of the array, including ones with nonzero upper address bits, show whether the address is taken modulo the array size and wraps. A read cut off in the middle of a byte, followed by a normal read, and an unknown opcode show that chip select restarts decoding and that the output stays off when it should.

// File: rtl/sfr_read.sv
module sfr_read #(
  parameter int AW   = 12,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ext_addr,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  output logic          so,
  output logic          so_oe,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata
);

  typedef enum logic [1:0] {ST_CMD, ST_ADDR, ST_DATA, ST_BAD} state_t;

  logic [SYNC:0]   sck_sh;
  logic [SYNC-1:0] cs_sh;
  logic [SYNC-1:0] si_sh;

  logic sck_rise, sck_fall, cs_hi, si_s;

  assign sck_rise = sck_sh[SYNC-1] & ~sck_sh[SYNC];
  assign sck_fall = ~sck_sh[SYNC-1] & sck_sh[SYNC];
  assign cs_hi    = cs_sh[SYNC-1];
  assign si_s     = si_sh[SYNC-1];

  state_t        state;
  logic [5:0]    cnt;
  logic [5:0]    alen;
  logic [6:0]    cmd;
  logic [AW-2:0] addr_sh;
  logic [2:0]    bidx;
  logic [6:0]    sh;
  logic [7:0]    nxt;
  logic          rd_pend;
  logic [7:0]    opc;

  assign opc = {cmd, si_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sh <= '0;
      cs_sh  <= '1;
      si_sh  <= '0;
    end else begin
      sck_sh <= {sck_sh[SYNC-1:0], sck};
      cs_sh  <= {cs_sh[SYNC-2:0], cs_n};
      si_sh  <= {si_sh[SYNC-2:0], si};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CMD;
      cnt       <= '0;
      alen      <= 6'd24;
      cmd       <= '0;
      addr_sh   <= '0;
      bidx      <= '0;
      sh        <= '0;
      nxt       <= '0;
      rd_pend   <= 1'b0;
      so        <= 1'b0;
      so_oe     <= 1'b0;
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      rd_pend   <= mem_rd_en;
      if (rd_pend) nxt <= mem_rdata;
      if (cs_hi) begin
        state <= ST_CMD;
        cnt   <= '0;
        bidx  <= '0;
        so_oe <= 1'b0;
      end else begin
        case (state)
          ST_CMD: if (sck_rise) begin
            cmd <= opc[6:0];
            cnt <= cnt + 6'd1;
            if (cnt == 6'd7) begin
              cnt <= '0;
              if (opc == 8'h03) begin
                alen  <= cfg_ext_addr ? 6'd32 : 6'd24;
                state <= ST_ADDR;
              end else if (opc == 8'h13) begin
                alen  <= 6'd32;
                state <= ST_ADDR;
              end else begin
                state <= ST_BAD;
              end
            end
          end
          ST_ADDR: if (sck_rise) begin
            addr_sh <= {addr_sh[AW-3:0], si_s};
            cnt     <= cnt + 6'd1;
            if (cnt == alen - 6'd1) begin
              mem_addr  <= {addr_sh, si_s};
              mem_rd_en <= 1'b1;
              cnt       <= '0;
              bidx      <= '0;
              state     <= ST_DATA;
            end
          end
          ST_DATA: if (sck_fall) begin
            so_oe <= 1'b1;
            bidx  <= bidx + 3'd1;
            if (bidx == 3'd0) begin
              so        <= nxt[7];
              sh        <= nxt[6:0];
              mem_addr  <= mem_addr + 1'b1;
              mem_rd_en <= 1'b1;
            end else begin
              so <= sh[6];
              sh <= {sh[5:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sfr_read_chk.sv
module sfr_read_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic so,
  input logic so_oe,
  input logic mem_rd_en,
  input logic sck_fall,
  input logic cs_hi
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> (!so_oe && !mem_rd_en));

  a_r5_oe_rise_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(sck_fall));

  a_r5_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && !$stable(so)) |-> $past(sck_fall));

  a_r8_cs_ends: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !so_oe);

  a_r6_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

endmodule

bind sfr_read sfr_read_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so(so), .so_oe(so_oe),
  .mem_rd_en(mem_rd_en), .sck_fall(sck_fall), .cs_hi(cs_hi)
);

// File: tb/sfr_read_test.sv
module sfr_read_test;
  localparam int AW = 12;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ext_addr = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic so, so_oe, mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  logic exp_oe = 1'b0;
  logic capture = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  sfr_read #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_ext_addr(cfg_ext_addr), .cs_n(cs_n),
    .sck(sck), .si(si), .so(so), .so_oe(so_oe), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= pat(mem_addr);

  // monitor
  int mbits = 0;
  logic [7:0] mbyte = 8'h00;
  always @(posedge sck) begin
    checks++;
    if (so_oe !== exp_oe) begin
      failures++;
      $display("FAIL %s/R5 so_oe got %0b exp %0b", tag, so_oe, exp_oe);
    end
    if (!capture) mbits = 0;
    else begin
      mbyte = {mbyte[6:0], so};
      mbits++;
      if (mbits == 8) begin
        mbits = 0;
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL %s/R6 extra byte got %02h exp none", tag, mbyte);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (mbyte !== e) begin
            failures++;
            $display("FAIL %s byte got %02h exp %02h", tag, mbyte, e);
          end
        end
      end
    end
  end

  task automatic xfer(input logic b);
    si = b;
    repeat (HP) @(negedge clk);
    sck = 1'b1;
    repeat (HP) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got %0h exp %0h", t, got, exp);
    end
  endtask

  task automatic do_read(input string t, input logic [7:0] op, input logic ext,
                         input logic [31:0] addr, input int alen, input int nbytes,
                         input int extra_bits, input logic good);
    tag = t;
    cfg_ext_addr = ext;
    exp_oe = 1'b0;
    capture = 1'b0;
    repeat (HP) @(negedge clk);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 7; i >= 0; i--) xfer(op[i]);
    for (int i = alen - 1; i >= 0; i--) xfer(addr[i]);
    if (good) begin
      for (int i = 0; i < nbytes; i++) exp_q.push_back(pat(AW'(addr + 32'(i))));
      exp_oe = 1'b1;
      capture = 1'b1;
    end
    for (int i = 0; i < nbytes * 8 + extra_bits; i++) xfer(1'b0);
    cs_n = 1'b1;
    capture = 1'b0;
    exp_oe = 1'b0;
    repeat (2 * HP) @(negedge clk);
    check({t, "/R8 so_oe after cs high"}, 32'(so_oe), 32'd0);
    check({t, "/R6 bytes left"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 so_oe after reset", 32'(so_oe), 32'd0);
    check("R1 mem_rd_en after reset", 32'(mem_rd_en), 32'd0);
    do_read("R2", 8'h03, 1'b0, 32'h0000_0123, 24, 4, 0, 1'b1);
    do_read("R3", 8'h03, 1'b1, 32'h0000_0456, 32, 3, 0, 1'b1);
    do_read("R4_ext0", 8'h13, 1'b0, 32'h0000_0789, 32, 3, 0, 1'b1);
    do_read("R4_ext1", 8'h13, 1'b1, 32'h0000_0A3C, 32, 3, 0, 1'b1);
    do_read("R7_4byte", 8'h13, 1'b0, 32'hFFFF_FFFE, 32, 4, 0, 1'b1);
    do_read("R7_3byte", 8'h03, 1'b0, 32'h00AB_CFFF, 24, 3, 0, 1'b1);
    do_read("R6_stream", 8'h03, 1'b0, 32'h0000_0F00, 24, 20, 0, 1'b1);
    do_read("R8_abort", 8'h03, 1'b0, 32'h0000_0010, 24, 2, 3, 1'b1);
    do_read("R8_after", 8'h03, 1'b0, 32'h0000_0200, 24, 2, 0, 1'b1);
    do_read("R9", 8'h9F, 1'b0, 32'h0000_0000, 24, 4, 0, 1'b0);
    do_read("R9_after", 8'h13, 1'b0, 32'h1234_5005, 32, 2, 0, 1'b1);
    check("R1 idle so_oe", 32'(so_oe), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule